// File: doc/BRIEF.md
# Serial Codec Register Access Controller

This block gives a host access to the control registers of an external codec over a framed, bit-serial link. The host writes one command word holding a codec register address, a read/write flag and a 16-bit data value. When the next frame begins, marked by a rising edge on the frame sync input, the pending command moves into a transmit shifter. It is then sent MSB first on the transmit line during the 64 bit times of the first subframe.

The codec always answers with the contents of the addressed register. The block captures that reply from the receive line and stores it in a readback register, whatever the read/write flag was, so a write also returns a read. The readback register updates in the bit time right after the 64-bit slot. A one-cycle done pulse marks the update. A busy flag covers the whole time from the host write until the reply is captured.

One clock cycle is one bit time. The frame sync input is synchronous to the clock.

Top module: `codec_reg_ctrl`

## Requirements
- R1: Bit time k of the slot is the cycle after the k-th clock edge that follows the loading edge, for k = 0 to 63. In bit times 0-3 the transmit line carries address bits 3..0. Bit time 4 carries the read/write flag. Bit times 5-20 carry data bits 15..0. Bit times 21-63 are low. The command word layout is {address[20:17], rw[16], data[15:0]}.
- R2: A pending command is loaded only at a clock edge where the frame sync input is high after having been low on the previous edge. A frame that starts with no command pending keeps the transmit line low and produces no done pulse. A host write made in the same cycle as the sync rise stays pending for the following frame.
- R3: The receive line is sampled in bit times 0-63. In bit time 64, done_o is high for exactly one cycle and the readback register takes {bit times 0-3, bit time 4, bit times 5-20} of the reply. Reply bit times 21-63 have no effect on it.
- R4: The readback register updates for commands with the rw flag low and with it high.
- R5: busy_o goes high in the cycle after a host write. It falls together with the done pulse, unless another command is pending.
- R6: A second host write made before the pending command is loaded replaces it, and only the newer command is transmitted.
- R7: A host write made after loading does not disturb the slot in progress. It is sent in the next frame, and busy_o stays high across the first done pulse.
- R8: After reset, or one cycle after enable_i is seen low, busy_o, done_o, txd_o and the readback register are all zero. Any pending command and any slot in progress are discarded.
- R9: A frame sync rise that occurs while a slot is in progress is ignored. The current slot continues unchanged and the pending command stays queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Port enable; low clears all state |
| host_wr_i | input | 1 | Host write strobe for the command word |
| host_wdata_i | input | 21 | Command word {addr, rw, data} |
| host_rdata_o | output | 21 | Readback of the last completed codec operation |
| busy_o | output | 1 | Command pending or in flight |
| done_o | output | 1 | One-cycle pulse when the readback updates |
| sfrm_i | input | 1 | Frame sync; a rising edge starts a frame |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |

## Verification
The bench uses the default widths: a 4-bit address, 16-bit data and a 64-bit slot. It sweeps all 16 addresses with both rw values and checks every transmitted bit. Each reply carries a pattern in the ignored tail of the slot. The bench also makes writes at chosen bit times inside a frame: in the sync cycle, before loading and after loading. It raises a second sync mid-slot and drops the enable mid-slot. These exercise replacement, deferral, sync rejection and abort.

// File: rtl/codec_pkg.sv
package codec_pkg;
  localparam int unsigned CR_ADDR_W = 4;
  localparam int unsigned CR_DATA_W = 16;
  localparam int unsigned CR_SLOT_W = 64;
endpackage

// File: rtl/codec_sync_detect.sv
module codec_sync_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sfrm_i,
  output logic rise_o
);
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sfrm_i;
  end

  assign rise_o = sfrm_i & ~sync_q;
endmodule

// File: rtl/codec_cmd_hold.sv
module codec_cmd_hold #(
  parameter int unsigned CMD_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CMD_W-1:0] wdata_i,
  input  logic             take_i,
  output logic             valid_o,
  output logic [CMD_W-1:0] cmd_o
);
  logic             valid_q;
  logic [CMD_W-1:0] cmd_q;

  // write wins over take: a write in the load cycle stays queued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cmd_q   <= '0;
    end else if (!en_i) begin
      valid_q <= 1'b0;
      cmd_q   <= '0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      cmd_q   <= wdata_i;
    end else if (take_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign cmd_o   = cmd_q;

  p_take_needs_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> valid_q);
endmodule

// File: rtl/codec_slot_shifter.sv
module codec_slot_shifter #(
  parameter int unsigned SLOT_W = 64,
  parameter int unsigned CMD_W  = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              rxd_i,
  output logic              active_o,
  output logic              txd_o,
  output logic              last_o,
  output logic [SLOT_W-1:0] rx_word_o
);
  localparam int unsigned CNT_W = $clog2(SLOT_W);
  localparam int unsigned PAD_W = SLOT_W - CMD_W;

  logic [SLOT_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              act_q;

  assign last_o    = act_q && (cnt_q == CNT_W'(SLOT_W - 1));
  assign rx_word_o = {rx_q[SLOT_W-2:0], rxd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      act_q <= 1'b0;
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (load_i) begin
        act_q <= 1'b1;
        tx_q  <= {cmd_i, {PAD_W{1'b0}}};
        rx_q  <= '0;
        cnt_q <= '0;
      end
    end else begin
      tx_q  <= {tx_q[SLOT_W-2:0], 1'b0};
      rx_q  <= rx_word_o;
      cnt_q <= cnt_q + 1'b1;
      if (last_o) act_q <= 1'b0;
    end
  end

  assign active_o = act_q;
  assign txd_o    = act_q & tx_q[SLOT_W-1];

  p_tail_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && cnt_q >= CNT_W'(CMD_W)) |-> !txd_o);
  p_slot_ends_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !act_q);
  p_start_on_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(load_i));
endmodule

// File: rtl/codec_reg_ctrl.sv
module codec_reg_ctrl
  import codec_pkg::*;
#(
  parameter int unsigned ADDR_W = CR_ADDR_W,
  parameter int unsigned DATA_W = CR_DATA_W,
  parameter int unsigned SLOT_W = CR_SLOT_W,
  localparam int unsigned CMD_W = ADDR_W + 1 + DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             host_wr_i,
  input  logic [CMD_W-1:0] host_wdata_i,
  output logic [CMD_W-1:0] host_rdata_o,
  output logic             busy_o,
  output logic             done_o,
  input  logic             sfrm_i,
  output logic             txd_o,
  input  logic             rxd_i
);
  logic              rise, pend_v, active, last, accept;
  logic [CMD_W-1:0]  pend_cmd;
  logic [SLOT_W-1:0] rx_word;
  logic [CMD_W-1:0]  rdata_q;
  logic              done_q;

  codec_sync_detect u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sfrm_i (sfrm_i),
    .rise_o (rise)
  );

  assign accept = enable_i & rise & pend_v & ~active;

  codec_cmd_hold #(.CMD_W(CMD_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enable_i),
    .wr_i    (host_wr_i),
    .wdata_i (host_wdata_i),
    .take_i  (accept),
    .valid_o (pend_v),
    .cmd_o   (pend_cmd)
  );

  codec_slot_shifter #(.SLOT_W(SLOT_W), .CMD_W(CMD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (enable_i),
    .load_i    (accept),
    .cmd_i     (pend_cmd),
    .rxd_i     (rxd_i),
    .active_o  (active),
    .txd_o     (txd_o),
    .last_o    (last),
    .rx_word_o (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else if (!enable_i) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (last) rdata_q <= rx_word[SLOT_W-1 -: CMD_W];
    end
  end

  assign host_rdata_o = rdata_q;
  assign done_o       = done_q;
  assign busy_o       = pend_v | active;

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_rdata_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && enable_i && $past(enable_i)) |-> $stable(host_rdata_o));
  p_busy_on_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && host_wr_i) |=> busy_o);
  p_clear_on_disable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!busy_o && !done_o && host_rdata_o == '0));
endmodule

// File: tb/codec_reg_ctrl_tb.sv
`timescale 1ns/1ps
module codec_reg_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        hwr = 1'b0;
  logic [20:0] hwd = '0;
  logic [20:0] hrd;
  logic        busy, done, txd;
  logic        sfrm = 1'b0;
  logic        rxd = 1'b0;
  int          n_chk = 0;
  int          n_err = 0;
  logic [20:0] rd_prev = '0;

  always #2.5 clk = ~clk;

  codec_reg_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .host_wr_i(hwr),
    .host_wdata_i(hwd), .host_rdata_o(hrd), .busy_o(busy), .done_o(done),
    .sfrm_i(sfrm), .txd_o(txd), .rxd_i(rxd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [20:0] v);
    @(negedge clk); hwr = 1'b1; hwd = v;
    @(negedge clk); hwr = 1'b0;
    chk("R5 busy after write", 64'(busy), 64'd1);
  endtask

  // on: slot expected; wr_k: bit time of a host write (-1 = sync cycle, -2 none)
  task automatic run_frame(input logic [20:0] cmd, input bit on, input logic [63:0] reply,
                           input int wr_k, input logic [20:0] wr_val, input int gl_k,
                           input bit busy_after);
    logic [63:0] word;
    logic [20:0] rd_exp;
    word   = on ? {cmd, 43'd0} : 64'd0;
    rd_exp = on ? reply[63:43] : rd_prev;
    @(negedge clk); sfrm = 1'b1; hwr = (wr_k == -1); hwd = wr_val;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      chk(on ? "R1 tx bit" : "R2 idle tx bit", 64'(txd), 64'(word[63-k]));
      chk("R3 no early done", 64'(done), 64'd0);
      rxd  = reply[63-k];
      sfrm = (k == gl_k);
      hwr  = (k == wr_k);
      hwd  = wr_val;
    end
    @(negedge clk); hwr = 1'b0; rxd = 1'b0;
    chk("R3 done at bit 64", 64'(done), 64'(on));
    chk("R3 R4 readback", 64'(hrd), 64'(rd_exp));
    chk("R5 R7 busy after slot", 64'(busy), 64'(busy_after));
    @(negedge clk);
    chk("R3 done one cycle", 64'(done), 64'd0);
    rd_prev = rd_exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [20:0] c, c2;
    logic [63:0] r;
    repeat (3) @(negedge clk);
    chk("R8 reset busy", 64'(busy), 64'd0);
    chk("R8 reset done", 64'(done), 64'd0);
    chk("R8 reset txd", 64'(txd), 64'd0);
    chk("R8 reset rdata", 64'(hrd), 64'd0);
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);

    // R1 R3 R4: all addresses, both rw values
    for (int a = 0; a < 16; a++) begin
      for (int w = 0; w < 2; w++) begin
        c = {4'(a), 1'(w), 16'((a * 4369) ^ (w != 0 ? 16'h5A3C : 16'hC3A5))};
        r = {4'(a), 1'(w), 16'(a * 771 + w * 97 + 13), 43'h2AAAAAAAAAA ^ 43'(a)};
        host_write(c);
        run_frame(c, 1'b1, r, -2, '0, -1, 1'b0);
      end
    end

    // R2: empty frame, reply tail junk everywhere
    run_frame('0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, -2, '0, -1, 1'b0);

    // R6: replacement before load
    host_write(21'h0A1234);
    host_write(21'h15BEEF);
    run_frame(21'h15BEEF, 1'b1, {21'h1C0FFE, 43'h7FFFFFFFFFF}, -2, '0, -1, 1'b0);

    // R7 R9: write after load, sync rise mid-slot
    host_write(21'h03ABCD);
    run_frame(21'h03ABCD, 1'b1, {21'h021111, 43'd0}, 5, 21'h1E5555, 10, 1'b1);
    run_frame(21'h1E5555, 1'b1, {21'h1F2222, 43'h1}, -2, '0, -1, 1'b0);

    // R2: write in sync cycle waits one frame
    run_frame('0, 1'b0, 64'd0, -1, 21'h1248AC, -1, 1'b1);
    run_frame(21'h1248AC, 1'b1, {21'h0FEDCB, 43'h0}, -2, '0, -1, 1'b0);

    // R8: disable mid-slot
    host_write(21'h1FFFFF);
    @(negedge clk); sfrm = 1'b1;
    repeat (8) @(negedge clk);
    sfrm = 1'b0; en = 1'b0;
    @(negedge clk);
    chk("R8 disable txd", 64'(txd), 64'd0);
    chk("R8 disable busy", 64'(busy), 64'd0);
    chk("R8 disable rdata", 64'(hrd), 64'd0);
    chk("R8 disable done", 64'(done), 64'd0);
    repeat (70) @(negedge clk);
    chk("R8 no late done", 64'(done), 64'd0);
    en = 1'b1; rd_prev = '0;
    run_frame('0, 1'b0, 64'hFFFF_0000_FFFF_0000, -2, '0, -1, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule